// File: doc/BRIEF.md
# Confidence-Based Fetch Gating Unit

This unit sits next to the fetch stage of a speculative pipeline. It stops instruction fetch while too many unresolved branches carry a low-confidence prediction. Each time the predictor marks a branch as doubtful, the unit counts it. Each time such a branch resolves, the count drops. The purpose is to keep wrong-path instructions out of the pipeline and so save the energy they would burn.

The live count is compared against a threshold that software programs. A registered stall output is raised while the count is above that threshold. A pipeline flush empties the count, since no speculative branch survives a flush. A saturating statistics counter records how many cycles fetch spent gated. Branch prediction, confidence estimation and the pipeline itself lie outside the unit.

Top module: `fetch_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, the in-flight count, the stall output and the gated-cycle statistic are all zero.
- R2: A low-confidence prediction pulse on its own raises the in-flight count by one at the next clock edge. A resolve pulse on its own lowers it by one.
- R3: A prediction pulse and a resolve pulse in the same cycle leave the in-flight count unchanged.
- R4: The in-flight count saturates at 2^CNT_W-1. A prediction pulse at that value leaves it there.
- R5: A resolve pulse while the in-flight count is zero has no effect, and the count stays at zero.
- R6: A flush clears the in-flight count to zero at the next clock edge, whatever the pulses in that cycle are. It also forces the stall output low at that same edge.
- R7: When there is no flush, the stall output at each clock edge equals (in-flight count > threshold), using the values from the cycle before. A count equal to the threshold does not stall.
- R8: The gated-cycle statistic rises by one for every cycle in which the stall output is high, and saturates at 2^STAT_W-1. A flush does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lowconf_pred_i | input | 1 | Pulse: a branch was predicted with low confidence |
| lowconf_resolve_i | input | 1 | Pulse: a low-confidence branch resolved |
| flush_i | input | 1 | Pipeline flush; empties the in-flight count |
| thresh_i | input | CNT_W | Programmed stall threshold |
| fetch_stall_o | output | 1 | Registered fetch stall |
| inflight_o | output | CNT_W | Current count of unresolved low-confidence branches |
| gated_cycles_o | output | STAT_W | Saturating count of stalled cycles |

## Verification
The in-flight count reflects a pulse one edge after it is presented. The stall output lags the count by one more edge, and the statistic lags the stall by one edge after that. The bench drives inputs and samples outputs on the falling edge. It advances a reference model by exactly one step per rising edge, so that each of these lags is checked in the cycle where it is due. The sweeps use a 3-bit counter and an 8-bit statistic, and cover every threshold under prediction-heavy, balanced and resolve-heavy traffic with random flushes. This drives both counters into saturation, drives the in-flight count against its zero floor, and brings the count level with the threshold.

// File: rtl/fg_pkg.sv
package fg_pkg;
  // Next in-flight count: saturating up, floored down, simultaneous pulses cancel.
  function automatic int unsigned step_count(int unsigned cur, int unsigned maxv,
                                             logic up, logic dn);
    if (up && !dn) return (cur >= maxv) ? maxv : cur + 1;
    if (dn && !up) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  // Saturating increment for the statistic.
  function automatic int unsigned sat_incr(int unsigned cur, int unsigned maxv, logic en);
    if (en && cur < maxv) return cur + 1;
    return cur;
  endfunction
endpackage

// File: rtl/fg_count.sv
module fg_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned CMAX = (1 << CNT_W) - 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= CNT_W'(fg_pkg::step_count(32'(cnt_q), CMAX, up_i, dn_i));
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fg_cmp.sv
module fg_cmp #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             clr_i,
  output logic             over_o,
  output logic             stall_o
);
  logic stall_q;

  assign over_o = (cnt_i > thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= over_o & ~clr_i;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/fg_stat.sv
module fg_stat #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  output logic [STAT_W-1:0] val_o
);
  localparam int unsigned SMAX = (STAT_W >= 32) ? 32'hFFFF_FFFF : ((1 << STAT_W) - 1);
  logic [STAT_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= STAT_W'(fg_pkg::sat_incr(32'(val_q), SMAX, en_i));
  end

  assign val_o = val_q;
endmodule

// File: rtl/fetch_gate.sv
module fetch_gate #(
  parameter int CNT_W  = 4,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lowconf_pred_i,
  input  logic              lowconf_resolve_i,
  input  logic              flush_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              fetch_stall_o,
  output logic [CNT_W-1:0]  inflight_o,
  output logic [STAT_W-1:0] gated_cycles_o
);
  // Named internal events, visible to the bound checker.
  logic             ev_inc;
  logic             ev_dec;
  logic             ev_flush;
  logic             cmp_over;
  logic [CNT_W-1:0] cnt_w;
  logic             stall_w;

  assign ev_inc   = lowconf_pred_i;
  assign ev_dec   = lowconf_resolve_i;
  assign ev_flush = flush_i;

  fg_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .up_i(ev_inc), .dn_i(ev_dec),
    .clr_i(ev_flush), .cnt_o(cnt_w)
  );

  fg_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .thr_i(thresh_i),
    .clr_i(ev_flush), .over_o(cmp_over), .stall_o(stall_w)
  );

  fg_stat #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .en_i(stall_w), .val_o(gated_cycles_o)
  );

  assign inflight_o    = cnt_w;
  assign fetch_stall_o = stall_w;
endmodule

// File: rtl/fg_chk.sv
module fg_chk #(
  parameter int CNT_W  = 4,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_inc,
  input logic              ev_dec,
  input logic              ev_flush,
  input logic [CNT_W-1:0]  thresh_i,
  input logic              fetch_stall_o,
  input logic [CNT_W-1:0]  inflight_o,
  input logic [STAT_W-1:0] gated_cycles_o
);
  localparam logic [CNT_W-1:0]  CMAX = '1;
  localparam logic [STAT_W-1:0] SMAX = '1;

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inc && !ev_dec && !ev_flush && inflight_o != CMAX) |=> inflight_o == $past(inflight_o) + 1'b1);

  p_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inc && ev_dec && !ev_flush) |=> $stable(inflight_o));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_o == CMAX && !ev_dec && !ev_flush) |=> inflight_o == CMAX);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_o == '0 && !ev_inc) |=> inflight_o == '0);

  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> (inflight_o == '0 && !fetch_stall_o));

  p_stall_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_flush |=> fetch_stall_o == ($past(inflight_o) > $past(thresh_i)));

  p_stat_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall_o && gated_cycles_o != SMAX) |=> gated_cycles_o == $past(gated_cycles_o) + 1'b1);

  p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall_o |=> $stable(gated_cycles_o));
endmodule

bind fetch_gate fg_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .ev_dec(ev_dec), .ev_flush(ev_flush),
  .thresh_i(thresh_i), .fetch_stall_o(fetch_stall_o), .inflight_o(inflight_o),
  .gated_cycles_o(gated_cycles_o)
);

// File: tb/sim_fetch_gate.sv
module sim_fetch_gate;
  localparam int CW = 3;
  localparam int SW = 8;
  localparam int CMAX = (1 << CW) - 1;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          pred, res, flush;
  logic [CW-1:0] thr;
  logic          stall;
  logic [CW-1:0] cnt;
  logic [SW-1:0] stat;

  fetch_gate #(.CNT_W(CW), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .lowconf_pred_i(pred), .lowconf_resolve_i(res),
    .flush_i(flush), .thresh_i(thr), .fetch_stall_o(stall), .inflight_o(cnt),
    .gated_cycles_o(stat)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m_cnt = 0, m_stall = 0, m_stat = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, clock once, then compare.
  task automatic step(input logic p, input logic r, input logic f, input int t);
    int    n_cnt, n_stall, n_stat;
    string tg;
    n_stall = (!f && m_cnt > t) ? 1 : 0;
    n_stat  = (m_stall != 0 && m_stat < SMAX) ? m_stat + 1 : m_stat;
    if (f)                                   begin n_cnt = 0;         tg = "R6"; end
    else if (p && r)                         begin n_cnt = m_cnt;     tg = "R3"; end
    else if (p && m_cnt == CMAX)             begin n_cnt = m_cnt;     tg = "R4"; end
    else if (p)                              begin n_cnt = m_cnt + 1; tg = "R2"; end
    else if (r && m_cnt == 0)                begin n_cnt = 0;         tg = "R5"; end
    else if (r)                              begin n_cnt = m_cnt - 1; tg = "R2"; end
    else                                     begin n_cnt = m_cnt;     tg = "R2"; end
    pred = p; res = r; flush = f; thr = CW'(t);
    @(posedge clk);
    @(negedge clk);
    m_cnt = n_cnt; m_stall = n_stall; m_stat = n_stat;
    check(tg, int'(cnt), m_cnt);
    check(f ? "R6" : "R7", int'(stall), m_stall);
    check("R8", int'(stat), m_stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pred = 1'b0; res = 1'b0; flush = 1'b0; thr = '0;
    repeat (3) @(negedge clk);
    check("R1", int'(cnt), 0);
    check("R1", int'(stall), 0);
    check("R1", int'(stat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(cnt), 0);
    check("R1", int'(stall), 0);
    check("R1", int'(stat), 0);

    // Directed: fill past the top with threshold at max (equal never stalls, R7).
    for (int i = 0; i < CMAX + 3; i++) step(1'b1, 1'b0, 1'b0, CMAX);
    step(1'b1, 1'b1, 1'b0, CMAX);                     // R3 at max
    step(1'b0, 1'b0, 1'b0, CMAX - 1);                 // count > thr: stall next
    step(1'b0, 1'b0, 1'b0, CMAX - 1);
    step(1'b1, 1'b0, 1'b1, 0);                        // flush beats increment, R6
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 0);  // R5 floor
    step(1'b1, 1'b1, 1'b0, 0);                        // R3 at zero

    // Sweeps: every threshold under three traffic mixes with random flushes.
    for (int mode = 0; mode < 3; mode++) begin
      for (int t = 0; t <= CMAX; t++) begin
        for (int c = 0; c < 200; c++) begin
          logic p, r, f;
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          case (mode)
            0: begin p = (lf[2:0] != 3'd0); r = (lf[5:3] == 3'd0); end
            1: begin p = lf[0];             r = lf[4];             end
            default: begin p = (lf[2:0] == 3'd0); r = (lf[5:3] != 3'd0); end
          endcase
          f = (lf[12:8] == 5'd0);
          step(p, r, f, t);
        end
      end
    end

    // Long stall to drive the statistic into saturation.
    step(1'b0, 1'b0, 1'b1, 0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 0);
    for (int i = 0; i < SMAX + 10; i++) step(1'b0, 1'b0, 1'b0, 0);
    check("R8", int'(stat), SMAX);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule